// File: doc/BRIEF.md
# Block-Transfer I2C Configuration Register Slave

This block is an I2C slave that keeps a small bank of 8-bit configuration registers, seven by default. It drives them in parallel onto a wide output bus for the surrounding logic to use. The registers hold fixed values after reset. A bus master can rewrite them with a block write and check them with a block read. The block samples SCL and SDA through a synchroniser and controls SDA as an open-drain pin through an output-enable. When the output-enable is high the pad pulls the line low.

A write always carries two header bytes after the address: a command byte and a length byte. The slave acknowledges both and then throws away their values. The data bytes that follow land in register 0, then register 1, and so on. The master may end the write with STOP after any complete byte. A read first returns a count byte, then the registers in ascending order. Any START or STOP resets the transfer, so the next transfer begins again at register 0. The slave supports only standard-mode timing and never stretches the clock.

Top module: `i2c_blk_slave`

## Requirements
- R1: The slave acknowledges the address byte D2h (7-bit address 69h, write) and D3h (69h, read). The address is sent MSB first, with the read/write flag in the LSB (1 = read).
- R2: For any other address byte the slave does not acknowledge and never drives SDA. It changes no register until the next START.
- R3: In a write, the first two bytes after the address (command and length) are both acknowledged, and their values never reach any register.
- R4: Write data bytes fill register 0, 1, 2, and so on in ascending order. The slave acknowledges each byte up to and including register 6.
- R5: If STOP follows any complete data byte, the registers already written keep their new values and every other register keeps its previous value.
- R6: Data bytes after register 6 in the same write are not acknowledged, and no register changes because of them.
- R7: A read returns the count byte 07h first, then registers 0 to 6, each MSB first. Any byte after register 6 reads as FFh.
- R8: After the master NACKs a read byte, the slave releases SDA. It drives nothing until the next STOP or START, and the next transfer is served normally.
- R9: After reset, registers 0 to 6 hold 3Ch, 81h, C3h, 00h, FFh, 0Fh, 5Ah. The slave does not drive SDA.
- R10: A START or a STOP releases SDA and clears the bit and byte position. After a repeated START inside a write, the new write begins again at register 0.
- R11: The slave asserts its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; SCL and SDA are sampled with it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| cfg_o | output | NUM_REGS*8 | Register contents; register i at bits [8i+7:8i] |

## Verification
The bench acts as a bus master. It runs these transfers:
- A full read straight after reset.
- A short write ended by STOP.
- A write that runs past the last register.
- A transfer to a foreign address.
- A write broken by a repeated START.
- A read that the master cuts short with a NACK.

The short write shows that the header bytes are thrown away and that the registers not written stay as they were. The overlong write separates the acknowledged data bytes from the extra bytes the slave refuses. The foreign address shows that the slave stays silent on the bus. The repeated START shows that the register pointer goes back to 0. The early NACK, followed by clocking one more byte and then a full read, shows that the slave lets go of SDA and can still serve the next transfer. A scoreboard compares every byte read back against a model of the registers that the bench updates from the requirements.

// File: rtl/i2c_blk_pkg.sv
package i2c_blk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDATA,
        ST_ACK,
        ST_TX,
        ST_RACK
    } xfer_state_t;
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic sda_o,
    output logic start_o,
    output logic stop_o
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev_q;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '1;
            else         chain_q <= {chain_q[SYNC_STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '1;
        else         prev_q <= synced;
    end

    assign scl_o      = synced[0];
    assign sda_o      = synced[1];
    assign scl_rise_o = synced[0] & ~prev_q[0];
    assign scl_fall_o = ~synced[0] & prev_q[0];
    // SDA edges with SCL steadily high
    assign start_o    = synced[0] & prev_q[0] & prev_q[1] & ~synced[1];
    assign stop_o     = synced[0] & prev_q[0] & ~prev_q[1] & synced[1];
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank #(
    parameter int                    NUM_REGS  = 7,
    parameter logic [NUM_REGS*8-1:0] CFG_RESET = '0,
    localparam int                   AW        = $clog2(NUM_REGS)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  we_i,
    input  logic [AW-1:0]         waddr_i,
    input  logic [7:0]            wdata_i,
    input  logic [AW-1:0]         raddr_i,
    output logic [7:0]            rdata_o,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    logic [NUM_REGS-1:0][7:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we_i) regs_d[waddr_i] = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= CFG_RESET;
        else         regs_q <= regs_d;
    end

    assign rdata_o = regs_q[raddr_i];
    assign cfg_o   = regs_q;

    // R6: no write strobe ever points past the last register
    assert_wr_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |-> (int'(waddr_i) < NUM_REGS));

    // R5: register contents move only on a write strobe
    assert_hold_without_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_i |=> $stable(cfg_o));
endmodule

// File: rtl/i2c_blk_slave.sv
module i2c_blk_slave
    import i2c_blk_pkg::*;
#(
    parameter int                    NUM_REGS    = 7,
    parameter logic [6:0]            DEV_ADDR    = 7'h69,
    parameter int                    SYNC_STAGES = 2,
    parameter logic [NUM_REGS*8-1:0] CFG_RESET   = 56'h5A0FFF00C3813C
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    localparam int                AW       = $clog2(NUM_REGS);
    localparam int                IDXW     = $clog2(NUM_REGS + 3);
    localparam logic [IDXW-1:0]   W_LIMIT  = IDXW'(NUM_REGS + 2);
    localparam logic [IDXW-1:0]   W_HDR    = IDXW'(2);
    localparam logic [IDXW-1:0]   R_LAST   = IDXW'(NUM_REGS);
    localparam logic [IDXW-1:0]   R_SAT    = IDXW'(NUM_REGS + 1);
    localparam logic [7:0]        CNT_BYTE = 8'(NUM_REGS);

    typedef struct packed {
        xfer_state_t     st;
        logic [3:0]      bitcnt;
        logic [7:0]      sh;
        logic            oe;
        logic            rd;
        logic            mack;
        logic [IDXW-1:0] widx;
        logic [IDXW-1:0] ridx;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_w, stop_w;
    logic we;
    logic [AW-1:0] waddr, raddr;
    logic [7:0] rdata, tx_byte;
    logic [IDXW-1:0] ridx_inc;

    i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) cond_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .sda_o      (sda_s),
        .start_o    (start_w),
        .stop_o     (stop_w)
    );

    cfg_bank #(.NUM_REGS(NUM_REGS), .CFG_RESET(CFG_RESET)) bank_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (ctx_q.sh),
        .raddr_i (raddr),
        .rdata_o (rdata),
        .cfg_o   (cfg_o)
    );

    // Byte to send next: count first, then registers, then filler
    assign raddr    = AW'(ctx_q.ridx - IDXW'(1));
    assign ridx_inc = (ctx_q.ridx == R_SAT) ? R_SAT : ctx_q.ridx + IDXW'(1);
    always_comb begin
        if (ctx_q.ridx == '0)         tx_byte = CNT_BYTE;
        else if (ctx_q.ridx <= R_LAST) tx_byte = rdata;
        else                           tx_byte = 8'hFF;
    end

    assign waddr = AW'(ctx_q.widx - W_HDR);

    always_comb begin
        ctx_d = ctx_q;
        we    = 1'b0;
        if (start_w) begin
            ctx_d.st     = ST_ADDR;
            ctx_d.bitcnt = '0;
            ctx_d.oe     = 1'b0;
        end else if (stop_w) begin
            ctx_d.st     = ST_IDLE;
            ctx_d.bitcnt = '0;
            ctx_d.oe     = 1'b0;
        end else begin
            unique case (ctx_q.st)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        ctx_d.sh     = {ctx_q.sh[6:0], sda_s};
                        ctx_d.bitcnt = ctx_q.bitcnt + 4'd1;
                    end else if (scl_fall && ctx_q.bitcnt == 4'd8) begin
                        ctx_d.bitcnt = '0;
                        if (ctx_q.st == ST_ADDR) begin
                            if (ctx_q.sh[7:1] == DEV_ADDR) begin
                                ctx_d.oe   = 1'b1;
                                ctx_d.rd   = ctx_q.sh[0];
                                ctx_d.widx = '0;
                                ctx_d.ridx = '0;
                                ctx_d.st   = ST_ACK;
                            end else begin
                                ctx_d.st = ST_IDLE;
                            end
                        end else begin
                            ctx_d.st = ST_ACK;
                            if (ctx_q.widx < W_LIMIT) begin
                                ctx_d.oe   = 1'b1;
                                ctx_d.widx = ctx_q.widx + IDXW'(1);
                                we         = (ctx_q.widx >= W_HDR);
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (ctx_q.rd) begin
                            ctx_d.sh   = tx_byte;
                            ctx_d.oe   = ~tx_byte[7];
                            ctx_d.ridx = ridx_inc;
                            ctx_d.st   = ST_TX;
                        end else begin
                            ctx_d.oe = 1'b0;
                            ctx_d.st = ST_WDATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (ctx_q.bitcnt == 4'd7) begin
                            ctx_d.oe     = 1'b0;
                            ctx_d.bitcnt = '0;
                            ctx_d.st     = ST_RACK;
                        end else begin
                            ctx_d.sh     = {ctx_q.sh[6:0], 1'b0};
                            ctx_d.oe     = ~ctx_q.sh[6];
                            ctx_d.bitcnt = ctx_q.bitcnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        ctx_d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (ctx_q.mack) begin
                            ctx_d.sh   = tx_byte;
                            ctx_d.oe   = ~tx_byte[7];
                            ctx_d.ridx = ridx_inc;
                            ctx_d.st   = ST_TX;
                        end else begin
                            ctx_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctx_q <= '{st: ST_IDLE, bitcnt: '0, sh: '0, oe: 1'b0, rd: 1'b0,
                       mack: 1'b0, widx: '0, ridx: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign sda_oe_o = ctx_q.oe;

    // R10: a STOP seen on the bus releases SDA on the next cycle
    assert_stop_releases_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_w |=> !sda_oe_o);

    // R10: a START seen on the bus releases SDA on the next cycle
    assert_start_releases_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_w |=> !sda_oe_o);

    // R11: SDA drive begins only while the synchronised SCL is low
    assert_drive_scl_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sda_oe_o && !$past(sda_oe_o)) |-> !scl_s);
endmodule

// File: tb/i2c_blk_slave_tb_top.sv
module i2c_blk_slave_tb_top;
    localparam int Q = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic        sda_line;
    logic [55:0] cfg;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit watch_oe = 1'b0;
    int oe_seen = 0;
    int r11_viol = 0;
    logic prev_oe = 1'b0;

    logic [7:0] exp_reg [7] = '{8'h3C, 8'h81, 8'hC3, 8'h00, 8'hFF, 8'h0F, 8'h5A};

    logic [7:0] exp_v [$];
    string      exp_r [$];
    logic [7:0] got_q [$];
    event       got_ev;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_blk_slave dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .cfg_o    (cfg)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // bus observers: R2 silence window and R11 drive timing
    always @(negedge clk) begin
        if (rst_n) begin
            if (watch_oe && sda_oe) oe_seen++;
            if (sda_oe && !prev_oe && scl_m) r11_viol++;
            prev_oe <= sda_oe;
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            logic [7:0] g, e;
            string r;
            @(got_ev);
            g = got_q.pop_front();
            e = exp_v.pop_front();
            r = exp_r.pop_front();
            chk(r, {24'h0, g}, {24'h0, e});
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(2 * Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        ack = ~sda_line; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic read_byte(input logic mack);
        logic [7:0] b;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl_m = 1'b1; wq(Q);
            b[i] = sda_line; wq(Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = ~mack; wq(Q);
        scl_m = 1'b1; wq(2 * Q);
        scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
        got_q.push_back(b);
        -> got_ev;
        wq(2);
    endtask

    // driver: push expected byte, then clock it in
    task automatic rd_expect(input logic [7:0] e, input string req, input logic mack);
        exp_v.push_back(e);
        exp_r.push_back(req);
        read_byte(mack);
    endtask

    task automatic wbyte(input logic [7:0] b, input logic exp_ack, input string req);
        logic a;
        write_byte(b, a);
        chk(req, {31'h0, a}, {31'h0, exp_ack});
    endtask

    task automatic chk_regs(input string req);
        for (int i = 0; i < 7; i++) chk(req, {24'h0, cfg[8*i +: 8]}, {24'h0, exp_reg[i]});
    endtask

    task automatic full_read(input string req);
        bus_start();
        wbyte(8'hD3, 1'b1, "R1");
        rd_expect(8'h07, req, 1'b1);
        for (int i = 0; i < 7; i++) rd_expect(exp_reg[i], req, 1'b1);
        rd_expect(8'hFF, req, 1'b0);
        bus_stop();
    endtask

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(5);
        // R9: reset values and released SDA
        chk_regs("R9");
        chk("R9", {31'h0, sda_oe}, 32'h0);
        full_read("R9");
        full_read("R7");

        // R3/R4/R5: short write ended after three data bytes
        bus_start();
        wbyte(8'hD2, 1'b1, "R1");
        wbyte(8'hAB, 1'b1, "R3");
        wbyte(8'h55, 1'b1, "R3");
        wbyte(8'h11, 1'b1, "R4"); exp_reg[0] = 8'h11;
        wbyte(8'h22, 1'b1, "R4"); exp_reg[1] = 8'h22;
        wbyte(8'h33, 1'b1, "R4"); exp_reg[2] = 8'h33;
        bus_stop();
        wq(10);
        chk_regs("R5");

        // R6: full write plus two extra bytes
        bus_start();
        wbyte(8'hD2, 1'b1, "R1");
        wbyte(8'h00, 1'b1, "R3");
        wbyte(8'h07, 1'b1, "R3");
        for (int i = 0; i < 7; i++) begin
            wbyte(8'hA0 + 8'(i), 1'b1, "R4");
            exp_reg[i] = 8'hA0 + 8'(i);
        end
        wbyte(8'hEE, 1'b0, "R6");
        wbyte(8'hDD, 1'b0, "R6");
        bus_stop();
        wq(10);
        chk_regs("R6");

        // R2: foreign address, bus ignored
        bus_start();
        watch_oe = 1'b1;
        wbyte(8'hA0, 1'b0, "R2");
        wbyte(8'h00, 1'b0, "R2");
        wbyte(8'h00, 1'b0, "R2");
        wbyte(8'h13, 1'b0, "R2");
        watch_oe = 1'b0;
        bus_stop();
        wq(10);
        chk("R2", 32'(oe_seen), 32'h0);
        chk_regs("R2");

        // R10: repeated START restarts the pointer at register 0
        bus_start();
        wbyte(8'hD2, 1'b1, "R1");
        wbyte(8'h01, 1'b1, "R3");
        wbyte(8'h02, 1'b1, "R3");
        wbyte(8'h99, 1'b1, "R4"); exp_reg[0] = 8'h99;
        bus_start();
        wbyte(8'hD2, 1'b1, "R10");
        wbyte(8'h01, 1'b1, "R10");
        wbyte(8'h02, 1'b1, "R10");
        wbyte(8'h77, 1'b1, "R10"); exp_reg[0] = 8'h77;
        bus_stop();
        wq(10);
        chk_regs("R10");

        // R8: master NACK ends the read early
        bus_start();
        wbyte(8'hD3, 1'b1, "R1");
        rd_expect(8'h07, "R7", 1'b1);
        rd_expect(exp_reg[0], "R7", 1'b1);
        rd_expect(exp_reg[1], "R8", 1'b0);
        chk("R8", {31'h0, sda_oe}, 32'h0);
        rd_expect(8'hFF, "R8", 1'b0);
        bus_stop();
        full_read("R8");

        chk("R11", 32'(r11_viol), 32'h0);
        wq(20);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog for all requirements got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule